// File: doc/BRIEF.md
# OSD Pixel Attribute Compositor

This block sits at the end of an on-screen-display pixel pipeline. For every pixel it receives a class from the glyph stage: foreground dot, border dot, character cell background, or page background. It also receives the 12-bit character word of the cell under the beam, the enable flags of the current text row, the page colour register and the control register.

From these inputs it decides what the pixel shows. The output is a 3-bit RGB colour code and a fast-blank signal that tells the video switch to insert the pixel. It also gives a flag that marks visible character foreground, and a selector that picks one of three luma levels.

The block holds a blink timer that counts field ticks. From that timer and the control register it decides whether blinking characters are in their visible phase. Mixed mode overlays text on live video and shows the video wherever no overlay is drawn. Full-page mode fills those same areas with the screen colour. All outputs are registered and follow the pixel inputs one clock later.

Top module: `osd_pix_compositor`

## Requirements
- R1: While rst_ni is low, rgb_o is 000, fblank_o is 0, char_act_o is 0, luma_sel_o is 00 and the blink timer is at count 0.
- R2: A visible foreground pixel (pix_class_i = 3) gives rgb_o = char_word_i[10:8], fblank_o = 1, luma_sel_o = 11 (char level) and char_act_o = 1, one clock after the inputs are presented. Colour codes: 000 black, 001 blue, 010 green, 011 cyan, 100 red, 101 magenta, 110 yellow, 111 white.
- R3: A character background pixel (pix_class_i = 1) is drawn only when char_word_i[11] is 1 and ctrl_i[1] is 0. It is then drawn with colour_i[2:0], fblank_o = 1 and luma_sel_o = 10 (screen level). Otherwise it is treated as page background.
- R4: When ctrl_i[3] is 1, border and character background pixels take char_word_i[10:8] instead of colour_i[8:6] and colour_i[2:0]. The page background always uses colour_i[11:9].
- R5: When border_en_i is 0, a border pixel (pix_class_i = 2) follows the character background rule of R3. When border_en_i is 1, a border pixel shows the border colour with luma_sel_o = 01 (black level) and fblank_o = 1.
- R6: When row_en_i is 0, every pixel class is drawn as page background and char_act_o stays 0.
- R7: A page background pixel (pix_class_i = 0) in mixed mode (ctrl_i[0] = 0) gives fblank_o = 0, rgb_o = 000 and luma_sel_o = 00 (video). In full-page mode (ctrl_i[0] = 1) it gives colour_i[11:9], fblank_o = 1 and luma_sel_o = 10. Whenever fblank_o is 0, rgb_o is 000 and luma_sel_o is 00.
- R8: The blink period is counted in field_tick_i pulses: FIELDS_50 when ctrl_i[8] is 1 and FIELDS_60 when it is 0, halved when ctrl_i[4] is 1. The count wraps to 0 on the tick that finds it at period-1 or above. The visible phase covers counts below floor(period*k/4), where k = 3, 2, 1 for ctrl_i[6:5] = 01, 10, 11. ctrl_i[6:5] = 00 keeps blinking characters always visible. Ticks move only the count, never the pixel path directly.
- R9: During the off phase, a foreground pixel with char_word_i[7] = 1 follows the character background rule of R3. char_act_o is 1 only for foreground pixels that are actually shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| field_tick_i | input | 1 | One-cycle pulse per video field |
| pix_class_i | input | 2 | 0 page bg, 1 char bg, 2 border, 3 foreground |
| char_word_i | input | 12 | bit 11 background enable, 10..8 colour, 7 blink enable, 6..0 code |
| row_en_i | input | 1 | Current row displayed |
| border_en_i | input | 1 | Current row draws borders |
| colour_i | input | 12 | 11..9 screen, 8..6 border, 2..0 char background colour |
| ctrl_i | input | 12 | 0 full page, 1 bg disable, 3 colour force, 4 half period, 6..5 duty, 8 50 Hz |
| rgb_o | output | 3 | Pixel colour code |
| fblank_o | output | 1 | Insert overlay pixel |
| char_act_o | output | 1 | Visible character foreground |
| luma_sel_o | output | 2 | 00 video, 01 black, 10 screen, 11 char level |

## Verification
Two functions can land on the same pixel and cycle: the blink off-phase of a foreground dot, and the character-background gating by bit 11 and ctrl_i[1]. When both apply, a blinking dot must fall through two rules and end as video or screen colour. The bench provokes this by stepping the field count across the duty boundary with directed ticks. Random ticks interleaved with random pixels and control words then keep hitting both phases. A bench model of the field count predicts the visible phase, and each pixel is judged against the expected colour, fast blank and luma choice.

// File: rtl/osd_pix_pkg.sv
package osd_pix_pkg;
  typedef enum logic [1:0] {
    PIX_PAGE = 2'd0,
    PIX_CBG  = 2'd1,
    PIX_BORD = 2'd2,
    PIX_FG   = 2'd3
  } pix_class_e;

  typedef enum logic [1:0] {
    LUMA_VIDEO  = 2'd0,
    LUMA_BLACK  = 2'd1,
    LUMA_SCREEN = 2'd2,
    LUMA_CHAR   = 2'd3
  } luma_sel_e;

  localparam int unsigned COL_W = 3;
  localparam int unsigned REG_W = 12;
endpackage

// File: rtl/osd_blink_timer.sv
module osd_blink_timer #(
  parameter int unsigned FIELDS_50 = 50,
  parameter int unsigned FIELDS_60 = 60
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       hz50_i,
  input  logic       half_i,
  input  logic [1:0] duty_i,
  output logic       visible_o
);
  localparam int unsigned MAXF  = (FIELDS_50 > FIELDS_60) ? FIELDS_50 : FIELDS_60;
  localparam int unsigned CNT_W = $clog2(MAXF + 1);
  localparam int unsigned PRD_W = CNT_W + 2;

  logic [CNT_W-1:0] cnt_q;
  logic [PRD_W-1:0] period, full, vis_len, cnt_ext;

  always_comb begin
    full    = hz50_i ? PRD_W'(FIELDS_50) : PRD_W'(FIELDS_60);
    period  = half_i ? (full >> 1) : full;
    vis_len = (period * (PRD_W'(4) - PRD_W'(duty_i))) >> 2;
    cnt_ext = PRD_W'(cnt_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= (cnt_ext + 1'b1 >= period) ? '0 : cnt_q + 1'b1;
  end

  assign visible_o = (duty_i == 2'b00) || (cnt_ext < vis_len);

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CNT_W'(MAXF)) else $error("blink count out of range"); // R8
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q)) else $error("blink count moved without tick"); // R8
endmodule

// File: rtl/osd_pix_classify.sv
module osd_pix_classify
  import osd_pix_pkg::*;
(
  input  pix_class_e cls_i,
  input  logic       bg_en_i,
  input  logic       blink_i,
  input  logic       bg_dis_i,
  input  logic       row_en_i,
  input  logic       bord_en_i,
  input  logic       blink_vis_i,
  output pix_class_e eff_o
);
  logic bg_shown;
  pix_class_e step;

  assign bg_shown = bg_en_i && !bg_dis_i;

  always_comb begin
    step = cls_i;
    if (!row_en_i)                                   step = PIX_PAGE;
    else if (cls_i == PIX_FG && blink_i && !blink_vis_i) step = PIX_CBG;
    else if (cls_i == PIX_BORD && !bord_en_i)        step = PIX_CBG;
    eff_o = (step == PIX_CBG && !bg_shown) ? PIX_PAGE : step;
  end
endmodule

// File: rtl/osd_pix_colour.sv
module osd_pix_colour
  import osd_pix_pkg::*;
(
  input  pix_class_e       eff_i,
  input  logic [COL_W-1:0] char_col_i,
  input  logic [REG_W-1:0] colour_i,
  input  logic             force_i,
  input  logic             full_page_i,
  output logic [COL_W-1:0] rgb_o,
  output logic             fblank_o,
  output logic             act_o,
  output luma_sel_e        luma_o
);
  always_comb begin
    rgb_o    = '0;
    fblank_o = 1'b1;
    act_o    = 1'b0;
    luma_o   = LUMA_SCREEN;
    unique case (eff_i)
      PIX_FG: begin
        rgb_o  = char_col_i;
        act_o  = 1'b1;
        luma_o = LUMA_CHAR;
      end
      PIX_BORD: begin
        rgb_o  = force_i ? char_col_i : colour_i[8:6];
        luma_o = LUMA_BLACK;
      end
      PIX_CBG: rgb_o = force_i ? char_col_i : colour_i[2:0];
      default: begin
        if (full_page_i) rgb_o = colour_i[11:9];
        else begin
          fblank_o = 1'b0;
          luma_o   = LUMA_VIDEO;
        end
      end
    endcase
  end
endmodule

// File: rtl/osd_pix_compositor.sv
module osd_pix_compositor
  import osd_pix_pkg::*;
#(
  parameter int unsigned FIELDS_50 = 50,
  parameter int unsigned FIELDS_60 = 60
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        field_tick_i,
  input  logic [1:0]  pix_class_i,
  input  logic [11:0] char_word_i,
  input  logic        row_en_i,
  input  logic        border_en_i,
  input  logic [11:0] colour_i,
  input  logic [11:0] ctrl_i,
  output logic [2:0]  rgb_o,
  output logic        fblank_o,
  output logic        char_act_o,
  output logic [1:0]  luma_sel_o
);
  logic             blink_vis;
  pix_class_e       eff;
  logic [COL_W-1:0] rgb_d;
  logic             fb_d, act_d;
  luma_sel_e        luma_d;

  osd_blink_timer #(.FIELDS_50(FIELDS_50), .FIELDS_60(FIELDS_60)) u_blink (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (field_tick_i),
    .hz50_i    (ctrl_i[8]),
    .half_i    (ctrl_i[4]),
    .duty_i    (ctrl_i[6:5]),
    .visible_o (blink_vis)
  );

  osd_pix_classify u_class (
    .cls_i       (pix_class_e'(pix_class_i)),
    .bg_en_i     (char_word_i[11]),
    .blink_i     (char_word_i[7]),
    .bg_dis_i    (ctrl_i[1]),
    .row_en_i    (row_en_i),
    .bord_en_i   (border_en_i),
    .blink_vis_i (blink_vis),
    .eff_o       (eff)
  );

  osd_pix_colour u_colour (
    .eff_i       (eff),
    .char_col_i  (char_word_i[10:8]),
    .colour_i    (colour_i),
    .force_i     (ctrl_i[3]),
    .full_page_i (ctrl_i[0]),
    .rgb_o       (rgb_d),
    .fblank_o    (fb_d),
    .act_o       (act_d),
    .luma_o      (luma_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rgb_o      <= '0;
      fblank_o   <= 1'b0;
      char_act_o <= 1'b0;
      luma_sel_o <= LUMA_VIDEO;
    end else begin
      rgb_o      <= rgb_d;
      fblank_o   <= fb_d;
      char_act_o <= act_d;
      luma_sel_o <= luma_d;
    end
  end

  AST_ACT_IS_CHAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    char_act_o |-> (fblank_o && luma_sel_o == LUMA_CHAR)) else $error("act without char luma"); // R9
  AST_VIDEO_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fblank_o |-> (rgb_o == '0 && luma_sel_o == LUMA_VIDEO)) else $error("video pixel not clean"); // R7
  AST_ROW_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !row_en_i |=> !char_act_o) else $error("disabled row drew foreground"); // R6
  AST_FULL_PAGE_FB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i[0] |=> fblank_o) else $error("full page left video"); // R7
  AST_BG_OFF_MIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_i[0] && pix_class_i == 2'd1 && (ctrl_i[1] || !char_word_i[11])) |=> !fblank_o)
    else $error("disabled char background inserted"); // R3
endmodule

// File: tb/osd_pix_compositor_tb.sv
module osd_pix_compositor_tb;
  localparam int CLK_PERIOD = 10;
  localparam int F50 = 50;
  localparam int F60 = 60;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        field_tick_i = 1'b0;
  logic [1:0]  pix_class_i = '0;
  logic [11:0] char_word_i = '0;
  logic        row_en_i = 1'b1;
  logic        border_en_i = 1'b1;
  logic [11:0] colour_i = '0;
  logic [11:0] ctrl_i = '0;
  logic [2:0]  rgb_o;
  logic        fblank_o, char_act_o;
  logic [1:0]  luma_sel_o;

  int checks = 0;
  int failures = 0;
  int bcnt = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  osd_pix_compositor u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .field_tick_i(field_tick_i),
    .pix_class_i(pix_class_i), .char_word_i(char_word_i), .row_en_i(row_en_i),
    .border_en_i(border_en_i), .colour_i(colour_i), .ctrl_i(ctrl_i),
    .rgb_o(rgb_o), .fblank_o(fblank_o), .char_act_o(char_act_o), .luma_sel_o(luma_sel_o)
  );

  function automatic int period_of(logic [11:0] c);
    int p = c[8] ? F50 : F60;
    return c[4] ? p / 2 : p;
  endfunction

  function automatic bit visible(logic [11:0] c, int cnt);
    int k;
    if (c[6:5] == 2'b00) return 1'b1;
    k = (c[6:5] == 2'b01) ? 3 : (c[6:5] == 2'b10) ? 2 : 1;
    return cnt < (period_of(c) * k) / 4;
  endfunction

  // {rgb, fb, act, luma}
  function automatic logic [6:0] expect_px(logic [1:0] cls, logic [11:0] w, bit row, bit bord,
                                           logic [11:0] col, logic [11:0] c, int cnt);
    logic [2:0] cc = w[10:8];
    bit bg_ok = w[11] && !c[1];
    logic [6:0] page = c[0] ? {col[11:9], 1'b1, 1'b0, 2'b10} : 7'b0;
    logic [6:0] cbg  = bg_ok ? {(c[3] ? cc : col[2:0]), 1'b1, 1'b0, 2'b10} : page;
    if (!row) return page;
    case (cls)
      2'd3: return (w[7] && !visible(c, cnt)) ? cbg : {cc, 1'b1, 1'b1, 2'b11};
      2'd2: return bord ? {(c[3] ? cc : col[8:6]), 1'b1, 1'b0, 2'b01} : cbg;
      2'd1: return cbg;
      default: return page;
    endcase
  endfunction

  task automatic check(string req, logic [6:0] exp);
    logic [6:0] act = {rgb_o, fblank_o, char_act_o, luma_sel_o};
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b (rgb fb act luma)", req, act, exp);
    end
  endtask

  task automatic pix(string req, logic [1:0] cls, logic [11:0] w, bit row, bit bord,
                     logic [11:0] col, logic [11:0] c);
    logic [6:0] e;
    pix_class_i = cls; char_word_i = w; row_en_i = row; border_en_i = bord;
    colour_i = col; ctrl_i = c;
    e = expect_px(cls, w, row, bord, col, c, bcnt);
    @(negedge clk);
    check(req, e);
  endtask

  task automatic tick();
    field_tick_i = 1'b1;
    @(negedge clk);
    field_tick_i = 1'b0;
    bcnt = (bcnt + 1 >= period_of(ctrl_i)) ? 0 : bcnt + 1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R1 reset", 7'b0);
    rst_ni = 1'b1;
    @(negedge clk);

    pix("R2 fg magenta", 2'd3, 12'h500, 1, 1, 12'h000, 12'h000);
    pix("R2 fg white",   2'd3, 12'h7A5, 1, 1, 12'h000, 12'h000);
    pix("R7 page mixed", 2'd0, 12'h700, 1, 1, 12'hC00, 12'h000);
    pix("R7 page full",  2'd0, 12'h700, 1, 1, 12'hC00, 12'h001);
    pix("R3 cbg on",     2'd1, 12'h800, 1, 1, 12'h003, 12'h000);
    pix("R3 cbg C1",     2'd1, 12'h800, 1, 1, 12'h003, 12'h002);
    pix("R3 cbg BE0 fp", 2'd1, 12'h000, 1, 1, 12'hA03, 12'h001);
    pix("R4 border reg", 2'd2, 12'h200, 1, 1, 12'h100, 12'h000);
    pix("R4 border frc", 2'd2, 12'h200, 1, 1, 12'h100, 12'h008);
    pix("R4 cbg forced", 2'd1, 12'hA00, 1, 1, 12'h005, 12'h008);
    pix("R4 page frc",   2'd0, 12'hA00, 1, 1, 12'h605, 12'h009);
    pix("R5 border off", 2'd2, 12'hA00, 1, 0, 12'h106, 12'h000);
    pix("R5 brd off BE0",2'd2, 12'h200, 1, 0, 12'h106, 12'h000);
    pix("R6 row off fg", 2'd3, 12'h300, 0, 1, 12'hE00, 12'h001);
    pix("R6 row off mx", 2'd3, 12'h300, 0, 1, 12'hE00, 12'h000);

    // blink: 50 Hz, 1.0 s, 0.75 duty -> period 50, visible below 37
    ctrl_i = 12'h120;
    pix("R8 blink cnt0", 2'd3, 12'hF80, 1, 1, 12'h001, 12'h120);
    repeat (36) tick();
    pix("R8 blink cnt36 vis", 2'd3, 12'hF80, 1, 1, 12'h001, 12'h120);
    tick();
    pix("R9 blink off cbg", 2'd3, 12'hF80, 1, 1, 12'h001, 12'h120);
    pix("R9 blink off video", 2'd3, 12'h780, 1, 1, 12'h001, 12'h120);
    pix("R9 blink off fp", 2'd3, 12'h780, 1, 1, 12'h401, 12'h121);
    pix("R8 duty off", 2'd3, 12'hF80, 1, 1, 12'h001, 12'h100);
    pix("R9 no BK shown", 2'd3, 12'hF00, 1, 1, 12'h001, 12'h120);
    repeat (12) tick();
    pix("R8 blink cnt49", 2'd3, 12'hF80, 1, 1, 12'h001, 12'h120);
    tick();
    pix("R8 blink wrap", 2'd3, 12'hF80, 1, 1, 12'h001, 12'h120);
    // 60 Hz, 0.5 s, 0.25 duty -> period 30, visible below 7
    ctrl_i = 12'h070;
    while (bcnt != 6) tick();
    pix("R8 half cnt6 vis", 2'd3, 12'hB80, 1, 1, 12'h002, 12'h070);
    tick();
    pix("R8 half cnt7 off", 2'd3, 12'hB80, 1, 1, 12'h002, 12'h070);

    for (int i = 0; i < 600; i++) begin
      logic [11:0] c = 12'($urandom) & 12'h17B;
      if ($urandom_range(0, 3) == 0) begin
        ctrl_i = c;
        tick();
      end
      pix("R2/R9 random", 2'($urandom), 12'($urandom), ($urandom_range(0, 4) != 0),
          1'($urandom), 12'($urandom), c);
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule